// File: doc/BRIEF.md
# Lane Request Coalescer

This block sits between a 16-lane execution group and the memory system. Each cycle a request may arrive in which every lane offers an enable bit and a byte address, and all lanes share one access width. The block gathers the enabled lanes whose addresses land in the same aligned 128-byte window, trims that window to the smallest aligned 64-byte or 32-byte piece that still holds every byte those lanes touch, and sends out one memory transaction for the group.

Transactions leave one at a time on a valid/ready port. Each carries an aligned base address, a size code, a mask of the lanes it serves, and a flag on the final one. The order or position of lanes inside a window has no effect on merging. The block takes no new request until the previous one has been fully issued. A request with no enabled lanes finishes in the cycle it is accepted.

Top module: `mem_coalescer`

## Requirements
- R1: A request is taken when req_valid_i and req_ready_o are both high. req_ready_o is high exactly when no transaction of an earlier request is still waiting, so it is never high while txn_valid_o is high.
- R2: txn_size_o encodes 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes. txn_addr_o is always a multiple of the encoded size.
- R3: All enabled lanes whose addresses share bits [31:7] go out in one transaction, whatever their order or offset inside that window. Each enabled lane appears in exactly one transaction mask.
- R4: A lane whose enable bit is low never appears in any mask, and its address has no effect on any transaction.
- R5: Lane i uses bytes addr..addr+w-1. The transaction is 64 bytes if all used bytes of its lanes lie in one aligned 64-byte half of the window, 32 bytes if they also lie in one aligned 32-byte quarter, and 128 bytes otherwise.
- R6: Transactions come out in ascending order of the lowest-numbered enabled lane not yet served.
- R7: txn_last_o is high only on the final transaction of a request. One cycle after that transaction is accepted, txn_valid_o is low and req_ready_o is high.
- R8: A request with all enable bits low produces no transaction, and req_ready_o stays high in the next cycle.
- R9: While txn_valid_o is high and txn_ready_i is low, the address, size, mask and last outputs hold their values.
- R10: req_width_i encodes 0 = 4 bytes, 1 = 8 bytes and 2 = 16 bytes (3 acts as 16). Every enabled lane address must be a multiple of the width.
- R11: After reset, req_ready_o is high and txn_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken |
| req_lane_en_i | input | 16 | Per-lane enable |
| req_addr_i | input | 512 | Lane byte addresses, lane i at bits [32*i+31:32*i] |
| req_width_i | input | 2 | Shared access width code |
| txn_valid_o | output | 1 | Transaction offered |
| txn_ready_i | input | 1 | Transaction taken downstream |
| txn_addr_o | output | 32 | Aligned transaction base address |
| txn_size_o | output | 2 | Transaction size code |
| txn_mask_o | output | 16 | Lanes served by this transaction |
| txn_last_o | output | 1 | Final transaction of the request |

## Verification
The bench applies consecutive runs of words from aligned and misaligned starting points. These show whether the window is trimmed to the correct half or quarter and whether a request that crosses a window is split in two. Permuted and broadcast patterns confirm that lane order and repeated addresses do not add transactions. Scattered addresses with sparse enables, some disabled lanes pointing at far windows, confirm that inactive lanes neither join a mask nor create a transaction. Random back-pressure on txn_ready_i holds transactions for several cycles, so the bench can check that held outputs stay stable and that the request port reopens right after the final transaction is accepted.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int SEG_BITS   = 7;   // 128-byte window
  localparam int CHUNK_BITS = 5;   // 32-byte quarter

  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } txn_size_e;

  function automatic logic [4:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 5'd4;
      2'd1:    width_bytes = 5'd8;
      default: width_bytes = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/coal_lead_pick.sv
module coal_lead_pick #(
  parameter int LANES = 16,
  localparam int IW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend_i,
  output logic [IW-1:0]    lead_o
);
  always_comb begin
    lead_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_i[i]) lead_o = IW'(i);
    end
  end
endmodule

// File: rtl/coal_seg_build.sv
module coal_seg_build
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(LANES)
) (
  input  logic [LANES-1:0]    pend_i,
  input  logic [LANES*AW-1:0] addr_i,
  input  logic [1:0]          wcode_i,
  input  logic [IW-1:0]       lead_i,
  output logic [LANES-1:0]    mask_o,
  output logic [AW-1:0]       base_o,
  output txn_size_e           size_o
);
  localparam int SW = AW - SEG_BITS;

  logic [SW-1:0] lead_seg;
  logic [4:0]    wb;
  logic [3:0]    span [LANES];
  logic [3:0]    cmap;

  assign lead_seg = addr_i[int'(lead_i)*AW + SEG_BITS +: SW];
  assign wb       = width_bytes(wcode_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0] la;
    logic [1:0]    c_lo, c_hi;
    logic [2:0]    c_end;
    assign la         = addr_i[g*AW +: AW];
    assign mask_o[g]  = pend_i[g] && (la[AW-1:SEG_BITS] == lead_seg);
    assign c_lo       = la[SEG_BITS-1:CHUNK_BITS];
    assign c_end      = 3'((8'(la[SEG_BITS-1:0]) + 8'(wb) - 8'd1) >> CHUNK_BITS);
    assign c_hi       = c_end[2] ? 2'd3 : c_end[1:0];
    always_comb begin
      for (int k = 0; k < 4; k++)
        span[g][k] = mask_o[g] && (2'(k) >= c_lo) && (2'(k) <= c_hi);
    end
  end

  always_comb begin
    cmap = '0;
    for (int i = 0; i < LANES; i++) cmap |= span[i];
  end

  logic       lo_used, hi_used;
  logic [1:0] pair;
  logic [1:0] quarter;

  always_comb begin
    lo_used = |cmap[1:0];
    hi_used = |cmap[3:2];
    pair    = hi_used ? cmap[3:2] : cmap[1:0];
    if (lo_used && hi_used) begin
      size_o  = SZ_128;
      quarter = 2'd0;
    end else if (pair == 2'b11) begin
      size_o  = SZ_64;
      quarter = {hi_used, 1'b0};
    end else begin
      size_o  = SZ_32;
      quarter = {hi_used, pair[1]};
    end
    base_o = {lead_seg, quarter, {CHUNK_BITS{1'b0}}};
  end

  // every served lane's start byte lies inside the issued window
  always_comb begin
    if (pend_i != '0) begin
      for (int i = 0; i < LANES; i++) begin
        if (mask_o[i]) begin
          AST_LANE_COVERED: assert ((addr_i[i*AW +: AW] - base_o) < (AW'(32) << size_o)); // R5
        end
      end
    end
  end
endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [LANES-1:0]    req_lane_en_i,
  input  logic [LANES*AW-1:0] req_addr_i,
  input  logic [1:0]          req_width_i,
  output logic                txn_valid_o,
  input  logic                txn_ready_i,
  output logic [AW-1:0]       txn_addr_o,
  output logic [1:0]          txn_size_o,
  output logic [LANES-1:0]    txn_mask_o,
  output logic                txn_last_o
);
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic [1:0]          wcode_q;
  logic [IW-1:0]       lead;
  txn_size_e           size;
  logic                req_fire, txn_fire;

  assign req_ready_o = (pend_q == '0);
  assign txn_valid_o = (pend_q != '0);
  assign req_fire    = req_valid_i && req_ready_o;
  assign txn_fire    = txn_valid_o && txn_ready_i;
  assign txn_size_o  = size;
  assign txn_last_o  = ((pend_q & ~txn_mask_o) == '0);

  coal_lead_pick #(.LANES(LANES)) u_lead (
    .pend_i (pend_q),
    .lead_o (lead)
  );

  coal_seg_build #(.LANES(LANES), .AW(AW)) u_seg (
    .pend_i  (pend_q),
    .addr_i  (addr_q),
    .wcode_i (wcode_q),
    .lead_i  (lead),
    .mask_o  (txn_mask_o),
    .base_o  (txn_addr_o),
    .size_o  (size)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      addr_q  <= '0;
      wcode_q <= '0;
    end else if (req_fire) begin
      pend_q  <= req_lane_en_i;
      addr_q  <= req_addr_i;
      wcode_q <= req_width_i;
    end else if (txn_fire) begin
      pend_q  <= pend_q & ~txn_mask_o;
    end
  end

  AST_REQ_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o); // R1

  AST_BASE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_size_o != 2'd3) &&
      ((txn_addr_o & ((AW'(32) << txn_size_o) - AW'(1))) == '0)); // R2

  AST_SERVED_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_fire |=> ((pend_q & $past(txn_mask_o)) == '0)); // R3

  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_fire && txn_last_o) |=> (!txn_valid_o && req_ready_o)); // R7

  AST_EMPTY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && req_lane_en_i == '0) |=> req_ready_o); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o && !txn_ready_i) |=> (txn_valid_o && $stable(txn_addr_o) &&
      $stable(txn_size_o) && $stable(txn_mask_o) && $stable(txn_last_o))); // R9

  for (genvar g = 0; g < LANES; g++) begin : g_align_chk
    AST_LANE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_fire && req_lane_en_i[g]) |->
        ((req_addr_i[g*AW +: AW] & AW'(width_bytes(req_width_i) - 5'd1)) == '0)); // R10
  end
endmodule

// File: tb/tb_mem_coalescer.sv
module tb_mem_coalescer;
  localparam int L  = 16;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic            req_ready_o;
  logic [L-1:0]    req_lane_en_i = '0;
  logic [L*AW-1:0] req_addr_i = '0;
  logic [1:0]      req_width_i = '0;
  logic            txn_valid_o;
  logic            txn_ready_i = 1'b0;
  logic [AW-1:0]   txn_addr_o;
  logic [1:0]      txn_size_o;
  logic [L-1:0]    txn_mask_o;
  logic            txn_last_o;

  always #2.5 clk = ~clk;

  mem_coalescer dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_lane_en_i(req_lane_en_i), .req_addr_i(req_addr_i), .req_width_i(req_width_i),
    .txn_valid_o(txn_valid_o), .txn_ready_i(txn_ready_i),
    .txn_addr_o(txn_addr_o), .txn_size_o(txn_size_o),
    .txn_mask_o(txn_mask_o), .txn_last_o(txn_last_o)
  );

  int unsigned total = 0, fails = 0;
  int unsigned a [L];
  logic [L-1:0] en;
  int          wc;
  int unsigned e_addr [L];
  int          e_size [L];
  logic [L-1:0] e_mask [L];
  int          e_n;

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run hung, got running expected done");
    summary();
    $finish;
  end

  function automatic int wbytes(int code);
    return (code == 0) ? 4 : (code == 1) ? 8 : 16;
  endfunction

  // reference: R3 R5 R6 grouping and trimming from byte ranges
  task automatic model();
    logic [L-1:0] left;
    int w;
    left = en; e_n = 0; w = wbytes(wc);
    while (left != 0) begin
      int lead, mn, mx;
      int unsigned seg;
      logic [L-1:0] m;
      lead = 0;
      for (int i = L - 1; i >= 0; i--) if (left[i]) lead = i;
      seg = a[lead] & ~32'd127;
      m = '0; mn = 1000; mx = -1;
      for (int i = 0; i < L; i++) begin
        if (left[i] && (a[i] & ~32'd127) == seg) begin
          int off;
          m[i] = 1'b1;
          off = int'(a[i] & 127);
          if (off < mn) mn = off;
          if (off + w - 1 > mx) mx = off + w - 1;
        end
      end
      if ((mn >> 6) != (mx >> 6)) begin
        e_size[e_n] = 2; e_addr[e_n] = seg;
      end else if ((mn >> 5) != (mx >> 5)) begin
        e_size[e_n] = 1; e_addr[e_n] = seg + (mn & 64);
      end else begin
        e_size[e_n] = 0; e_addr[e_n] = seg + (mn & 96);
      end
      e_mask[e_n] = m;
      left &= ~m;
      e_n++;
    end
  endtask

  task automatic chk(string tag, logic ok, string got, string exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %s expected %s", tag, got, exp);
    end
  endtask

  // drives en/a/wc as one request and follows it to completion
  task automatic run_req(string tag);
    int j;
    model();
    @(negedge clk);
    chk({tag, " R1 ready before request"}, req_ready_o === 1'b1,
        $sformatf("%b", req_ready_o), "1");
    req_valid_i = 1'b1; req_lane_en_i = en; req_width_i = 2'(wc);
    for (int i = 0; i < L; i++) req_addr_i[i*AW +: AW] = a[i];
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int i = 0; i < L; i++) req_addr_i[i*AW +: AW] = $urandom;
    req_lane_en_i = 16'($urandom);
    j = 0;
    while (j < e_n) begin
      logic rdy;
      logic ok;
      rdy = ($urandom % 4) != 0;
      txn_ready_i = rdy;
      ok = txn_valid_o === 1'b1 && txn_addr_o === e_addr[j] &&
           txn_size_o === 2'(e_size[j]) && txn_mask_o === e_mask[j] &&
           txn_last_o === (j == e_n - 1) && req_ready_o === 1'b0;
      chk($sformatf("%s R2 R3 R4 R5 R6 R7 R9 txn %0d", tag, j), ok,
          $sformatf("v=%b addr=%0d size=%0d mask=%h last=%b", txn_valid_o,
                    txn_addr_o, txn_size_o, txn_mask_o, txn_last_o),
          $sformatf("v=1 addr=%0d size=%0d mask=%h last=%b", e_addr[j],
                    e_size[j], e_mask[j], j == e_n - 1));
      @(negedge clk);
      if (rdy) j++;
    end
    txn_ready_i = 1'b0;
    chk({tag, " R7 R8 idle after request"}, txn_valid_o === 1'b0 && req_ready_o === 1'b1,
        $sformatf("v=%b rdy=%b", txn_valid_o, req_ready_o), "v=0 rdy=1");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #12;
    chk("R11 reset state", req_ready_o === 1'b1 && txn_valid_o === 1'b0,
        $sformatf("rdy=%b v=%b", req_ready_o, txn_valid_o), "rdy=1 v=0");
    @(negedge clk); rst_ni = 1'b1;

    // aligned run of words: one 64-byte piece (R5)
    wc = 0; en = '1;
    for (int i = 0; i < L; i++) a[i] = 128 + 4 * i;
    run_req("dir aligned");
    chk("R5 aligned run issues one 64B", e_n == 1 && e_size[0] == 1 && e_addr[0] == 128,
        $sformatf("n=%0d", e_n), "n=1");

    // misaligned run 116..176: 32B at 96 plus 64B at 128
    for (int i = 0; i < L; i++) a[i] = 116 + 4 * i;
    run_req("dir misaligned");
    chk("R5 misaligned split", e_n == 2 && e_addr[0] == 96 && e_size[0] == 0 &&
        e_addr[1] == 128 && e_size[1] == 1, $sformatf("n=%0d", e_n), "32B@96 + 64B@128");

    // permuted within one window (R3)
    for (int i = 0; i < L; i++) a[i] = 1024 + 4 * ((i * 7) % 16);
    run_req("dir permuted R3");

    // inactive lanes pointing far away (R4)
    en = 16'h0F0F;
    for (int i = 0; i < L; i++) a[i] = en[i] ? 256 + 4 * i : 32'h00F0_0000 + 128 * i;
    run_req("dir inactive R4");

    // 16-byte accesses over two windows: two 128B pieces
    wc = 2; en = '1;
    for (int i = 0; i < L; i++) a[i] = 512 + 16 * i;
    run_req("dir wide");

    // empty request (R8)
    en = '0;
    run_req("dir empty R8");

    // broadcast: one lane address shared by all
    wc = 1; en = 16'hFFFF;
    for (int i = 0; i < L; i++) a[i] = 2048 + 40;
    run_req("dir broadcast");

    for (int n = 0; n < 400; n++) begin
      int mode, w;
      int unsigned base;
      wc = $urandom % 3; w = wbytes(wc);
      mode = $urandom % 4;
      base = ($urandom % 64) * 512;
      en = ($urandom % 5 == 0) ? '1 : 16'($urandom);
      for (int i = 0; i < L; i++) begin
        case (mode)
          0: a[i] = base + w * (i + (n % 8));
          1: a[i] = base + (($urandom % 384) & ~(w - 1));
          2: a[i] = base + w * ((i * 5 + n) % 16) + 32 * (n % 3);
          default: a[i] = base + w * (n % 24);
        endcase
      end
      run_req($sformatf("rnd %0d m%0d R10 w%0d", n, mode, w));
    end

    summary();
    $finish;
  end
endmodule